// File: doc/BRIEF.md
# Masked Memory Bank Address Decoder

This block maps a physical address to one of four logical memory banks. Each bank holds a decode word with four parts and an enable bit. Two of the parts are compared against an upper field and a lower field of the address. The other two are don't-care masks: they mark bits that are left out of the comparison. A lookup request returns, one clock later, a strobe, a hit or miss flag, the winning bank index and a global bank number built from the port number. When more than one bank matches, the lowest-numbered bank wins.

The same decode words also describe the shape of each bank. The decoder presents these values continuously for all four banks. The interleave factor comes from the lower mask. The base address is the upper match value with its masked bits cleared. The size is computed from the low ten bits of the upper mask and divided by the interleave factor. Software or a boot engine loads the decode words through a one-cycle write port.

The result path is a three-state machine. `S_IDLE` means no result. `S_HIT` and `S_MISS` mean that a result is being presented. The transitions are: any state goes to `S_IDLE` when there is no request; any state goes to `S_HIT` on a request that matches; any state goes to `S_MISS` on a request that matches no bank.

Top module: `mem_bank_decoder`

## Requirements
- R1: After reset every decode word is zero, so all banks are disabled and no result strobe is raised until a lookup is made.
- R2: A write with `cfg_we` high stores `cfg_wdata` into bank `cfg_bank`. The field layout is: bit 32 enable, bits 31:20 upper mask, bits 19:8 upper match, bits 7:4 lower mask, bits 3:0 lower match. A bank whose enable bit is 0 never matches.
- R3: The upper field of the address (12 bits at `UPPER_SHIFT`) matches when every bit that is clear in the upper mask equals the same bit of the upper match value. Bits that are set in the mask are ignored.
- R4: The lower field of the address (4 bits at `LOWER_SHIFT`) is compared against the lower match value under the lower mask in the same way. A hit needs both fields to match.
- R5: When several enabled banks match, the bank with the lowest index is reported.
- R6: `rsp_valid` is high for exactly the cycle after a cycle with `lk_req` high, and low otherwise.
- R7: On a miss, `rsp_miss` is 1, `rsp_hit` is 0 and `rsp_bank` is 0. On a hit, `rsp_hit` is 1 and `rsp_miss` is 0.
- R8: `rsp_gid` equals 4 × `port_id` (sampled with the request) plus the reported bank index.
- R9: The interleave factor of a bank follows its lower mask: 0xF gives 1, 0xE gives 2, 0xC gives 4, 0x8 gives 8, 0x0 gives 16, and any other value gives 1.
- R10: The base of a bank is (upper match AND NOT upper mask) shifted left by `UPPER_SHIFT`.
- R11: The size of a bank is (upper mask bits 9:0 plus one) shifted left by `UPPER_SHIFT`, then divided by the interleave factor. Mask bits 11:10 do not affect it.
- R12: A write in the same cycle as a lookup does not affect that lookup. It applies from the next lookup onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Decode word write enable |
| cfg_bank | input | 2 | Bank being written |
| cfg_wdata | input | 33 | Decode word, layout as in R2 |
| port_id | input | PORT_W (5) | Port number of this controller |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | PA_W (45) | Physical address to decode |
| rsp_valid | output | 1 | Result strobe |
| rsp_hit | output | 1 | An enabled bank matched |
| rsp_miss | output | 1 | No bank matched |
| rsp_bank | output | 2 | Winning bank index, 0 on a miss |
| rsp_gid | output | PORT_W+2 (7) | Global bank number |
| bank_ileave | output | 4×5 | Interleave factor per bank, bank 0 in the low bits |
| bank_base | output | 4×PA_W | Base address per bank |
| bank_size | output | 4×PA_W | Size per bank |

## Verification
A decode-word write and a lookup can fall in the same cycle, and the write may target the bank that would decide the lookup. The bench provokes this on purpose. It first arranges a case where the address hits under the old word and misses under the new one. It then drives the write and the request on the same edge. The result must follow the old word, and a second lookup of the same address must follow the new one. The randomized phase also mixes writes and lookups freely, and each result is compared with a model that applies writes only after the lookup has been judged.

// File: rtl/bank_dec_pkg.sv
package bank_dec_pkg;
    localparam int UK_W = 12;
    localparam int LK_W = 4;
    localparam int SIZE_BITS = 10;

    typedef struct packed {
        logic            en;
        logic [UK_W-1:0] up_mask;
        logic [UK_W-1:0] up_val;
        logic [LK_W-1:0] lo_mask;
        logic [LK_W-1:0] lo_val;
    } dec_word_t;

    localparam int DEC_W = $bits(dec_word_t);

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_HIT  = 2'd1,
        S_MISS = 2'd2
    } rsp_state_t;
endpackage

// File: rtl/bank_dec_regs.sv
module bank_dec_regs
    import bank_dec_pkg::*;
#(
    parameter int NB = 4,
    localparam int BW = $clog2(NB)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [BW-1:0]       sel,
    input  logic [DEC_W-1:0]    wdata,
    output dec_word_t [NB-1:0]  words
);
    dec_word_t [NB-1:0] words_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            words_q <= '0;
        end else if (we) begin
            words_q[sel] <= dec_word_t'(wdata);
        end
    end

    assign words = words_q;

    for (genvar b = 0; b < NB; b++) begin : g_chk
        assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (we && sel == BW'(b)) |=> (words_q[b] == $past(wdata)));
        assert_hold_unwritten_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && sel == BW'(b)) |=> $stable(words_q[b]));
    end
endmodule

// File: rtl/bank_dec_match.sv
module bank_dec_match
    import bank_dec_pkg::*;
#(
    parameter int PA_W = 45,
    parameter int UPPER_SHIFT = 33,
    parameter int LOWER_SHIFT = 6
) (
    input  dec_word_t        word,
    input  logic [PA_W-1:0]  addr,
    output logic             hit
);
    logic [UK_W-1:0] up_f;
    logic [LK_W-1:0] lo_f;
    logic            up_ok;
    logic            lo_ok;

    assign up_f  = addr[UPPER_SHIFT +: UK_W];
    assign lo_f  = addr[LOWER_SHIFT +: LK_W];
    assign up_ok = ((up_f ^ word.up_val) & ~word.up_mask) == '0;
    assign lo_ok = ((lo_f ^ word.lo_val) & ~word.lo_mask) == '0;
    assign hit   = word.en && up_ok && lo_ok;
endmodule

// File: rtl/bank_dec_geom.sv
module bank_dec_geom
    import bank_dec_pkg::*;
#(
    parameter int PA_W = 45,
    parameter int UPPER_SHIFT = 33
) (
    input  dec_word_t        word,
    output logic [4:0]       ileave,
    output logic [PA_W-1:0]  base,
    output logic [PA_W-1:0]  size
);
    logic [2:0]      lg;
    logic [PA_W-1:0] span;

    always_comb begin
        unique case (word.lo_mask)
            4'hE:    begin ileave = 5'd2;  lg = 3'd1; end
            4'hC:    begin ileave = 5'd4;  lg = 3'd2; end
            4'h8:    begin ileave = 5'd8;  lg = 3'd3; end
            4'h0:    begin ileave = 5'd16; lg = 3'd4; end
            default: begin ileave = 5'd1;  lg = 3'd0; end
        endcase
    end

    assign base = PA_W'(word.up_val & ~word.up_mask) << UPPER_SHIFT;
    assign span = PA_W'({1'b0, word.up_mask[SIZE_BITS-1:0]} + 11'd1) << UPPER_SHIFT;
    assign size = span >> lg;

    always_comb begin
        assert_ileave_pow2_R9: assert ($onehot(ileave));
    end
endmodule

// File: rtl/mem_bank_decoder.sv
module mem_bank_decoder
    import bank_dec_pkg::*;
#(
    parameter int NB = 4,
    parameter int PA_W = 45,
    parameter int UPPER_SHIFT = 33,
    parameter int LOWER_SHIFT = 6,
    parameter int PORT_W = 5,
    localparam int BW = $clog2(NB),
    localparam int GID_W = PORT_W + BW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [BW-1:0]        cfg_bank,
    input  logic [DEC_W-1:0]     cfg_wdata,
    input  logic [PORT_W-1:0]    port_id,
    input  logic                 lk_req,
    input  logic [PA_W-1:0]      lk_addr,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic                 rsp_miss,
    output logic [BW-1:0]        rsp_bank,
    output logic [GID_W-1:0]     rsp_gid,
    output logic [NB*5-1:0]      bank_ileave,
    output logic [NB*PA_W-1:0]   bank_base,
    output logic [NB*PA_W-1:0]   bank_size
);
    dec_word_t [NB-1:0] words;
    logic [NB-1:0]      hits;
    logic               any_hit;
    logic [BW-1:0]      win;
    rsp_state_t         state_q, state_d;
    logic [BW-1:0]      bank_q;
    logic [GID_W-1:0]   gid_q;

    bank_dec_regs #(.NB(NB)) regs_i (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_bank),
        .wdata(cfg_wdata), .words(words)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        bank_dec_match #(.PA_W(PA_W), .UPPER_SHIFT(UPPER_SHIFT), .LOWER_SHIFT(LOWER_SHIFT)) match_i (
            .word(words[b]), .addr(lk_addr), .hit(hits[b])
        );
        bank_dec_geom #(.PA_W(PA_W), .UPPER_SHIFT(UPPER_SHIFT)) geom_i (
            .word(words[b]),
            .ileave(bank_ileave[b*5 +: 5]),
            .base(bank_base[b*PA_W +: PA_W]),
            .size(bank_size[b*PA_W +: PA_W])
        );
    end

    // lowest index wins: scan from the top so lower banks overwrite
    always_comb begin
        win = '0;
        for (int b = NB - 1; b >= 0; b--) begin
            if (hits[b]) win = BW'(b);
        end
    end
    assign any_hit = |hits;

    always_comb begin
        if (!lk_req)      state_d = S_IDLE;
        else if (any_hit) state_d = S_HIT;
        else              state_d = S_MISS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            bank_q  <= '0;
            gid_q   <= '0;
        end else begin
            state_q <= state_d;
            if (lk_req) begin
                bank_q <= any_hit ? win : '0;
                gid_q  <= {port_id, (any_hit ? win : BW'(0))};
            end
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_hit   = 1'b0;
        rsp_miss  = 1'b0;
        unique case (state_q)
            S_HIT:   begin rsp_valid = 1'b1; rsp_hit  = 1'b1; end
            S_MISS:  begin rsp_valid = 1'b1; rsp_miss = 1'b1; end
            default: ;
        endcase
        rsp_bank = bank_q;
        rsp_gid  = gid_q;
    end

    assert_strobe_follows_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid);
    assert_no_strobe_without_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_valid);
    assert_hit_miss_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_hit, rsp_miss}));
    assert_miss_bank_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_bank == '0));
    assert_gid_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> (rsp_gid[GID_W-1:BW] == $past(port_id)));
    assert_winner_matched_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && any_hit) |-> hits[win]);
endmodule

// File: tb/mem_bank_decoder_tb_top.sv
module mem_bank_decoder_tb_top;
    localparam int NB = 4;
    localparam int PA_W = 45;
    localparam int US = 33;
    localparam int LS = 6;
    localparam int PW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_bank = '0;
    logic [32:0] cfg_wdata = '0;
    logic [PW-1:0] port_id = '0;
    logic lk_req = 1'b0;
    logic [PA_W-1:0] lk_addr = '0;
    logic rsp_valid, rsp_hit, rsp_miss;
    logic [1:0] rsp_bank;
    logic [PW+1:0] rsp_gid;
    logic [NB*5-1:0] bank_ileave;
    logic [NB*PA_W-1:0] bank_base, bank_size;

    int checks = 0;
    int errors = 0;
    logic [32:0] m_reg [NB];

    always #2 clk = ~clk;

    mem_bank_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
        .cfg_wdata(cfg_wdata), .port_id(port_id), .lk_req(lk_req), .lk_addr(lk_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_bank(rsp_bank), .rsp_gid(rsp_gid), .bank_ileave(bank_ileave),
        .bank_base(bank_base), .bank_size(bank_size)
    );

    function automatic logic [32:0] mk(input logic en, input logic [11:0] um_k, input logic [11:0] um_v,
                                       input logic [3:0] lm_k, input logic [3:0] lm_v);
        return {en, um_k, um_v, lm_k, lm_v};
    endfunction

    function automatic logic m_match(input logic [32:0] w, input logic [PA_W-1:0] a);
        logic [11:0] up;
        logic [3:0] lo;
        up = a[US +: 12];
        lo = a[LS +: 4];
        if (!w[32]) return 1'b0;
        for (int i = 0; i < 12; i++)
            if (!w[20+i] && (up[i] != w[8+i])) return 1'b0;
        for (int i = 0; i < 4; i++)
            if (!w[4+i] && (lo[i] != w[i])) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int m_ileave(input logic [3:0] k);
        case (k)
            4'hF: return 1;
            4'hE: return 2;
            4'hC: return 4;
            4'h8: return 8;
            4'h0: return 16;
            default: return 1;
        endcase
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_word(input int b, input logic [32:0] w);
        cfg_we = 1'b1; cfg_bank = 2'(b); cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
        m_reg[b] = w;
    endtask

    task automatic expect_lookup(input logic [PA_W-1:0] a, output logic eh, output int eb);
        eh = 1'b0; eb = 0;
        for (int b = NB - 1; b >= 0; b--)
            if (m_match(m_reg[b], a)) begin eh = 1'b1; eb = b; end
    endtask

    task automatic check_rsp(input string tag, input logic eh, input int eb);
        chk({tag, " R6 strobe"}, longint'(rsp_valid), 1);
        chk({tag, " R7 hit"}, longint'(rsp_hit), longint'(eh));
        chk({tag, " R7 miss"}, longint'(rsp_miss), longint'(!eh));
        chk({tag, " R5 bank"}, longint'(rsp_bank), longint'(eb));
        chk({tag, " R8 gid"}, longint'(rsp_gid), longint'(port_id) * 4 + eb);
    endtask

    task automatic lookup(input string tag, input logic [PA_W-1:0] a);
        logic eh;
        int eb;
        expect_lookup(a, eh, eb);
        lk_req = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_req = 1'b0;
        check_rsp(tag, eh, eb);
    endtask

    task automatic check_geom(input string tag);
        for (int b = 0; b < NB; b++) begin
            int il;
            longint base_e, size_e;
            il = m_ileave(m_reg[b][7:4]);
            base_e = longint'(m_reg[b][19:8] & ~m_reg[b][31:20]) << US;
            size_e = ((longint'(m_reg[b][29:20]) + 1) << US) / il;
            chk({tag, " R9 ileave"}, longint'(bank_ileave[b*5 +: 5]), il);
            chk({tag, " R10 base"}, longint'(bank_base[b*PA_W +: PA_W]), base_e);
            chk({tag, " R11 size"}, longint'(bank_size[b*PA_W +: PA_W]), size_e);
        end
    endtask

    function automatic logic [PA_W-1:0] addr_of(input logic [11:0] up, input logic [3:0] lo);
        logic [PA_W-1:0] a;
        a = PA_W'($urandom) ^ (PA_W'($urandom) << 32);
        a[US +: 12] = up;
        a[LS +: 4] = lo;
        return a;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic eh;
        int eb;
        void'($urandom(32'd20240611));
        for (int b = 0; b < NB; b++) m_reg[b] = '0;
        port_id = 5'd3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 no strobe after reset", longint'(rsp_valid), 0);
        check_geom("R1 reset");
        lookup("R1 disabled banks", addr_of(12'h000, 4'h0));

        // R2: disabled word never matches, enabled one does
        write_word(0, mk(1'b0, 12'h000, 12'h005, 4'hF, 4'h0));
        lookup("R2 disabled", addr_of(12'h005, 4'h0));
        write_word(0, mk(1'b1, 12'h000, 12'h005, 4'hF, 4'h0));
        lookup("R2 enabled", addr_of(12'h005, 4'h9));
        check_geom("R2");

        // R3: upper mask don't-care bits
        write_word(1, mk(1'b1, 12'h00F, 12'h010, 4'hF, 4'h0));
        lookup("R3 masked bits differ", addr_of(12'h01A, 4'h3));
        lookup("R3 unmasked bit differs", addr_of(12'h02A, 4'h3));

        // R4: lower mask 0xC ignores bits 3:2
        write_word(2, mk(1'b1, 12'h000, 12'h100, 4'hC, 4'h3));
        lookup("R4 lower match", addr_of(12'h100, 4'h7));
        lookup("R4 lower mismatch", addr_of(12'h100, 4'h1));
        check_geom("R4 R9");

        // R5: bank 3 matches everything
        write_word(3, mk(1'b1, 12'hFFF, 12'h000, 4'hF, 4'h0));
        lookup("R5 lower bank wins", addr_of(12'h005, 4'h2));
        lookup("R5 fallback bank", addr_of(12'h7FF, 4'h2));

        // R6: no strobe without request
        @(negedge clk);
        chk("R6 idle no strobe", longint'(rsp_valid), 0);

        // R8: other port id
        port_id = 5'd31;
        lookup("R8 port 31", addr_of(12'h100, 4'h3));

        // R11: mask bits 11:10 ignored in size
        write_word(3, mk(1'b1, 12'hC05, 12'hFFF, 4'h8, 4'h0));
        check_geom("R11 high mask bits");

        // R12: same-cycle write and lookup
        write_word(3, mk(1'b0, 12'h000, 12'h000, 4'hF, 4'h0));
        write_word(1, mk(1'b1, 12'h000, 12'h0AA, 4'hF, 4'h0));
        expect_lookup(addr_of(12'h0AA, 4'h0), eh, eb);
        lk_req = 1'b1; lk_addr = addr_of(12'h0AA, 4'h0);
        cfg_we = 1'b1; cfg_bank = 2'd1; cfg_wdata = mk(1'b1, 12'h000, 12'h0AB, 4'hF, 4'h0);
        @(negedge clk);
        lk_req = 1'b0; cfg_we = 1'b0;
        check_rsp("R12 old word used", eh, eb);
        chk("R12 old word hit", longint'(rsp_hit), 1);
        m_reg[1] = mk(1'b1, 12'h000, 12'h0AB, 4'hF, 4'h0);
        lookup("R12 new word used", addr_of(12'h0AA, 4'h0));
        chk("R12 new word miss", longint'(rsp_miss), 1);

        // randomized mix
        for (int it = 0; it < 400; it++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r < 3) begin
                logic [3:0] kk;
                int sel;
                sel = $urandom_range(0, 5);
                case (sel)
                    0: kk = 4'hF; 1: kk = 4'hE; 2: kk = 4'hC;
                    3: kk = 4'h8; 4: kk = 4'h0; default: kk = 4'($urandom);
                endcase
                write_word($urandom_range(0, 3),
                           mk(($urandom_range(0, 3) != 0), 12'($urandom) & 12'($urandom),
                              12'($urandom), kk, 4'($urandom)));
                check_geom("R9 R10 R11 random");
            end else begin
                int b;
                logic [PA_W-1:0] a;
                b = $urandom_range(0, 3);
                if (r < 8)
                    a = addr_of(m_reg[b][19:8] ^ (m_reg[b][31:20] & 12'($urandom)),
                                m_reg[b][3:0] ^ (m_reg[b][7:4] & 4'($urandom)));
                else
                    a = addr_of(12'($urandom), 4'($urandom));
                if (r == 9) port_id = 5'($urandom);
                lookup("R3 R4 R5 random", a);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule